// File: doc/BRIEF.md
# Victim Cache Swap Unit

This block pairs a direct-mapped main line store with a small fully associative second-chance store. A lookup is compared against the main set selected by the low address bits and against every second-chance entry at the same time. A hit in the main store is answered in the same cycle. A hit in the second-chance store is answered with a one-cycle stall. During that stall the two lines trade places, so the requester's retry hits in the main store.

When a lookup misses in both stores and the main set holds a valid line, that line is pushed into the second-chance store. The push takes one cycle. The target slot is the lowest empty slot if one exists, and otherwise a slot chosen by a free-running pseudo-random sequence. A dirty line pushed out of the second-chance store is offered on a write-back port during the stall cycle. Refill of the main store comes from the memory side through a simple fill port. Fetching that data is outside this block.

Top module: `vc_swap_unit`

## Requirements
- R1: When `req_valid` and `ready` are both high, exactly one of `rsp_hit`, `rsp_vhit` and `rsp_miss` is high in that same cycle. Main-store hits take priority, and `rsp_data` carries the hit line on `rsp_hit` and is zero otherwise. The set index is `req_addr[1:0]` and the stored tag is `req_addr[7:2]`.
- R2: A lookup answered with `rsp_vhit` drives `ready` low for exactly the following cycle, and `ready` is high again in the cycle after that.
- R3: On a second-chance hit, the main set's valid line moves into the same second-chance slot with its full address, data and dirty bit, and the hitting line takes the main set.
- R4: A repeated lookup of the same address after the stall returns `rsp_hit` with the swapped-in line's data.
- R5: If the main set was empty during a swap, the second-chance entry becomes empty and the moved line is still found in the main store.
- R6: On a miss in both stores with a valid main line, that line moves into the second-chance store, the main set becomes empty, and `ready` is low for one cycle. A miss on an empty main set causes no stall.
- R7: The insertion slot is the lowest-numbered empty slot. When all slots are full, the slot is the low two bits of an 8-bit LFSR. The LFSR is 1 at reset and on every clock becomes `{q[6:0], q[7]^q[5]^q[4]^q[3]}`. The slot uses the value held before that edge.
- R8: When an insertion overwrites a valid dirty entry, `wb_valid` is high during the stall cycle with that entry's address and data. Overwriting a clean entry raises nothing.
- R9: `fill_valid` writes the set `fill_addr[1:0]` with tag, data and dirty bit when `ready` is high and `req_valid` is low. A fill while `ready` is low is ignored.
- R10: After reset every entry is empty, `ready` is high and `wb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 8 | Line address of the lookup |
| ready | output | 1 | Low during a swap or insertion stall |
| rsp_hit | output | 1 | Hit in the main store |
| rsp_vhit | output | 1 | Hit in the second-chance store; retry after the stall |
| rsp_miss | output | 1 | Miss in both stores |
| rsp_data | output | 32 | Line data on a main hit |
| fill_valid | input | 1 | Write a line into the main store |
| fill_addr | input | 8 | Line address of the fill |
| fill_data | input | 32 | Line data of the fill |
| fill_dirty | input | 1 | Dirty bit of the fill |
| wb_valid | output | 1 | Dirty line evicted from the second-chance store |
| wb_addr | output | 8 | Address of the evicted line |
| wb_data | output | 32 | Data of the evicted line |

## Verification
The bench targets a swap whose main set is empty. A design that copied a stale main line back would keep a phantom entry that later hits with wrong data. It also targets insertion once every slot is full. A design that picked the slot with the wrong LFSR phase or ignored empty slots would lose a line that the reference model still holds, and a later lookup would diverge from it. It checks dirty evictions, which would vanish or carry the new line's address if the capture happened after the overwrite. It also checks fills issued in the stall cycle, which a design that did not gate them would accept.

// File: rtl/vc_pkg.sv
package vc_pkg;
    localparam int LFSR_W = 8;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

    function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] q);
        return {q[LFSR_W-2:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
    endfunction
endpackage

// File: rtl/vc_lfsr.sv
module vc_lfsr (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [vc_pkg::LFSR_W-1:0] value
);
    logic [vc_pkg::LFSR_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = vc_pkg::lfsr_next(lfsr_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= vc_pkg::LFSR_SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign value = lfsr_q;

    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/vc_match.sv
module vc_match #(
    parameter int ADDR_W = 8,
    parameter int VICT   = 4,
    localparam int V_W   = $clog2(VICT)
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [VICT-1:0]              vld,
    input  logic [VICT-1:0][ADDR_W-1:0]  tags,
    output logic [VICT-1:0]              hits,
    output logic                         any,
    output logic [V_W-1:0]               sel
);
    for (genvar i = 0; i < VICT; i++) begin : g_cmp
        assign hits[i] = vld[i] && (tags[i] == addr);
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < VICT; i++) begin
            if (hits[i]) sel = V_W'(i);
        end
    end

    assign any = |hits;
endmodule

// File: rtl/vc_pick.sv
module vc_pick #(
    parameter int VICT  = 4,
    parameter int RND_W = 8,
    localparam int V_W  = $clog2(VICT)
) (
    input  logic [VICT-1:0]  vld,
    input  logic [RND_W-1:0] rnd,
    output logic [V_W-1:0]   slot
);
    always_comb begin
        slot = rnd[V_W-1:0];
        for (int i = VICT - 1; i >= 0; i--) begin
            if (!vld[i]) slot = V_W'(i);
        end
    end
endmodule

// File: rtl/vc_swap_unit.sv
module vc_swap_unit #(
    parameter int ADDR_W = 8,
    parameter int LINE_W = 32,
    parameter int SETS   = 4,
    parameter int VICT   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              rsp_hit,
    output logic              rsp_vhit,
    output logic              rsp_miss,
    output logic [LINE_W-1:0] rsp_data,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              fill_dirty,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int V_W   = $clog2(VICT);

    typedef struct packed {
        logic [SETS-1:0]             m_vld;
        logic [SETS-1:0]             m_dty;
        logic [SETS-1:0][TAG_W-1:0]  m_tag;
        logic [SETS-1:0][LINE_W-1:0] m_dat;
        logic [VICT-1:0]             v_vld;
        logic [VICT-1:0]             v_dty;
        logic [VICT-1:0][ADDR_W-1:0] v_adr;
        logic [VICT-1:0][LINE_W-1:0] v_dat;
        logic                        busy;
        logic                        wbv;
        logic [ADDR_W-1:0]           wba;
        logic [LINE_W-1:0]           wbd;
    } state_t;

    state_t st_d, st_q;

    logic [vc_pkg::LFSR_W-1:0] rnd;
    logic [IDX_W-1:0]          idx, fidx;
    logic [TAG_W-1:0]          tag;
    logic [VICT-1:0]           vhits;
    logic                      vany;
    logic [V_W-1:0]            vsel, ins_slot;
    logic                      main_hit, look;

    assign idx  = req_addr[IDX_W-1:0];
    assign tag  = req_addr[ADDR_W-1:IDX_W];
    assign fidx = fill_addr[IDX_W-1:0];

    vc_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .value(rnd));

    vc_match #(.ADDR_W(ADDR_W), .VICT(VICT)) u_match (
        .addr(req_addr), .vld(st_q.v_vld), .tags(st_q.v_adr),
        .hits(vhits), .any(vany), .sel(vsel)
    );

    vc_pick #(.VICT(VICT), .RND_W(vc_pkg::LFSR_W)) u_pick (
        .vld(st_q.v_vld), .rnd(rnd), .slot(ins_slot)
    );

    always_comb begin
        look     = req_valid && !st_q.busy;
        main_hit = st_q.m_vld[idx] && (st_q.m_tag[idx] == tag);
        ready    = !st_q.busy;
        rsp_hit  = look && main_hit;
        rsp_vhit = look && !main_hit && vany;
        rsp_miss = look && !main_hit && !vany;
        rsp_data = rsp_hit ? st_q.m_dat[idx] : '0;
        wb_valid = st_q.wbv;
        wb_addr  = st_q.wba;
        wb_data  = st_q.wbd;
    end

    always_comb begin
        st_d      = st_q;
        st_d.busy = 1'b0;
        st_d.wbv  = 1'b0;
        if (rsp_vhit) begin
            st_d.m_vld[idx]  = 1'b1;
            st_d.m_tag[idx]  = tag;
            st_d.m_dty[idx]  = st_q.v_dty[vsel];
            st_d.m_dat[idx]  = st_q.v_dat[vsel];
            st_d.v_vld[vsel] = st_q.m_vld[idx];
            st_d.v_adr[vsel] = {st_q.m_tag[idx], idx};
            st_d.v_dty[vsel] = st_q.m_dty[idx];
            st_d.v_dat[vsel] = st_q.m_dat[idx];
            st_d.busy        = 1'b1;
        end else if (rsp_miss && st_q.m_vld[idx]) begin
            if (st_q.v_vld[ins_slot] && st_q.v_dty[ins_slot]) begin
                st_d.wbv = 1'b1;
                st_d.wba = st_q.v_adr[ins_slot];
                st_d.wbd = st_q.v_dat[ins_slot];
            end
            st_d.v_vld[ins_slot] = 1'b1;
            st_d.v_adr[ins_slot] = {st_q.m_tag[idx], idx};
            st_d.v_dty[ins_slot] = st_q.m_dty[idx];
            st_d.v_dat[ins_slot] = st_q.m_dat[idx];
            st_d.m_vld[idx]      = 1'b0;
            st_d.busy            = 1'b1;
        end else if (fill_valid && !req_valid && !st_q.busy) begin
            st_d.m_vld[fidx] = 1'b1;
            st_d.m_tag[fidx] = fill_addr[ADDR_W-1:IDX_W];
            st_d.m_dty[fidx] = fill_dirty;
            st_d.m_dat[fidx] = fill_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_one_answer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |-> $onehot({rsp_hit, rsp_vhit, rsp_miss}));
    assert_vhit_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vhit |=> !ready);
    assert_stall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);
    assert_unique_victim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vhits));
    assert_swap_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vhit |=> (st_q.m_vld[$past(idx)] && st_q.m_tag[$past(idx)] == $past(tag)));
    assert_miss_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |=> !st_q.m_vld[$past(idx)]);
    assert_wb_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !ready);
    assert_stall_freezes_main_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (st_q.m_vld == $past(st_q.m_vld)));
endmodule

// File: tb/vc_swap_unit_tb.sv
module vc_swap_unit_tb;
    localparam int NS = 4;
    localparam int NV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, fill_valid = 1'b0, fill_dirty = 1'b0;
    logic [7:0]  req_addr = '0, fill_addr = '0;
    logic [31:0] fill_data = '0;
    logic        ready, rsp_hit, rsp_vhit, rsp_miss, wb_valid;
    logic [31:0] rsp_data, wb_data;
    logic [7:0]  wb_addr;

    always #5 clk = ~clk;

    vc_swap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .ready(ready), .rsp_hit(rsp_hit), .rsp_vhit(rsp_vhit), .rsp_miss(rsp_miss),
        .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_data(fill_data), .fill_dirty(fill_dirty), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    int          m_mv[NS], m_mt[NS], m_md[NS];
    logic [31:0] m_mdat[NS];
    int          m_vv[NV], m_va[NV], m_vd[NV];
    logic [31:0] m_vdat[NV];
    int          m_busy, m_wbv, m_wba, m_lfsr;
    logic [31:0] m_wbd;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit present(input int a);
        if (m_mv[a % NS] && m_mt[a % NS] == a / NS) return 1;
        for (int j = 0; j < NV; j++) if (m_vv[j] && m_va[j] == a) return 1;
        return 0;
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic step(input bit rq, input int a, input bit fv, input int fa,
                        input logic [31:0] fd, input bit fdy, input string tag);
        int idx, tg, vj, slot, fi, nb;
        bit rdy, look, mh, eh, ev, em;
        req_valid = rq; req_addr = 8'(a);
        fill_valid = fv; fill_addr = 8'(fa); fill_data = fd; fill_dirty = fdy;
        #1;
        rdy = (m_busy == 0);
        look = rq && rdy;
        idx = a % NS; tg = a / NS;
        mh = m_mv[idx] && m_mt[idx] == tg;
        vj = -1;
        for (int j = 0; j < NV; j++) if (m_vv[j] && m_va[j] == a) vj = j;
        eh = look && mh;
        ev = look && !mh && vj >= 0;
        em = look && !mh && vj < 0;
        chk("R2", "ready", ready, rdy);
        chk(tag, "rsp_hit", rsp_hit, eh);
        chk(tag, "rsp_vhit", rsp_vhit, ev);
        chk(tag, "rsp_miss", rsp_miss, em);
        chk(tag, "rsp_data", rsp_data, eh ? m_mdat[idx] : 32'h0);
        chk("R8", "wb_valid", wb_valid, m_wbv);
        if (m_wbv) begin
            chk("R8", "wb_addr", wb_addr, m_wba);
            chk("R8", "wb_data", wb_data, m_wbd);
        end
        @(posedge clk);
        m_busy = 0; m_wbv = 0;
        if (ev) begin
            int o_vv, o_vd; logic [31:0] o_vdat;
            o_vv = m_vv[vj]; o_vd = m_vd[vj]; o_vdat = m_vdat[vj];
            m_vv[vj] = m_mv[idx]; m_va[vj] = m_mt[idx] * NS + idx;
            m_vd[vj] = m_md[idx]; m_vdat[vj] = m_mdat[idx];
            m_mv[idx] = 1; m_mt[idx] = tg; m_md[idx] = o_vd; m_mdat[idx] = o_vdat;
            m_busy = 1;
        end else if (em && m_mv[idx]) begin
            slot = -1;
            for (int j = NV - 1; j >= 0; j--) if (!m_vv[j]) slot = j;
            if (slot < 0) slot = m_lfsr % NV;
            if (m_vv[slot] && m_vd[slot]) begin
                m_wbv = 1; m_wba = m_va[slot]; m_wbd = m_vdat[slot];
            end
            m_vv[slot] = 1; m_va[slot] = m_mt[idx] * NS + idx;
            m_vd[slot] = m_md[idx]; m_vdat[slot] = m_mdat[idx];
            m_mv[idx] = 0;
            m_busy = 1;
        end else if (fv && !rq && rdy) begin
            fi = fa % NS;
            m_mv[fi] = 1; m_mt[fi] = fa / NS; m_md[fi] = fdy; m_mdat[fi] = fd;
        end
        nb = ((m_lfsr >> 7) ^ (m_lfsr >> 5) ^ (m_lfsr >> 4) ^ (m_lfsr >> 3)) & 1;
        m_lfsr = ((m_lfsr << 1) & 255) | nb;
        @(negedge clk);
    endtask

    task automatic look(input int a, input string tag);
        step(1, a, 0, 0, 0, 0, tag);
    endtask
    task automatic fill(input int a, input logic [31:0] d, input bit dy, input string tag);
        step(0, 0, 1, a, d, dy, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lcg;
        for (int i = 0; i < NS; i++) begin m_mv[i] = 0; m_mt[i] = 0; m_md[i] = 0; m_mdat[i] = 0; end
        for (int j = 0; j < NV; j++) begin m_vv[j] = 0; m_va[j] = 0; m_vd[j] = 0; m_vdat[j] = 0; end
        m_busy = 0; m_wbv = 0; m_wba = 0; m_wbd = 0; m_lfsr = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10", "ready after reset", ready, 1);
        chk("R10", "wb_valid after reset", wb_valid, 0);
        chk("R10", "no answer after reset", {rsp_hit, rsp_vhit, rsp_miss}, 0);
        look(8'h10, "R10");                    // empty store: miss, no stall
        look(8'h10, "R6");                     // no stall followed
        fill(8'h10, 32'hA0A0_0010, 0, "R9");
        look(8'h10, "R1");                     // main hit
        look(8'h14, "R6");                     // miss, 0x10 pushed to slot 0
        idle("R6");
        look(8'h10, "R5");                     // vhit, main empty -> entry freed
        idle("R2");
        look(8'h10, "R4");                     // retry hits main
        look(8'h14, "R6");                     // push 0x10 again
        idle("R6");
        fill(8'h14, 32'hB0B0_0014, 1, "R9");
        look(8'h10, "R3");                     // swap with dirty 0x14
        idle("R2");
        look(8'h10, "R4");
        look(8'h14, "R3");                     // 0x14 came back with its data
        idle("R2");
        look(8'h14, "R4");
        // stall-cycle fill must be ignored
        look(8'h25, "R6");                     // empty set 1: no stall
        fill(8'h25, 32'hC0C0_0025, 0, "R9");
        look(8'h29, "R6");                     // push 0x25, stall next
        fill(8'h2D, 32'hDEAD_002D, 1, "R9");   // during stall: ignored
        look(8'h2D, "R9");                     // must miss, set empty
        // fill the victim store then force random, dirty evictions
        for (int k = 0; k < 12; k++) begin
            int a;
            a = 8'h40 + k * 4 + (k % 3);
            fill(a, 32'h5000_0000 + k, k % 2, "R9");
            look(a + 4 * 16, "R7");
            idle("R8");
        end
        for (int k = 0; k < 8; k++) look(8'h40 + k * 4 + (k % 3), "R7");
        // mixed random traffic
        lcg = 12345;
        for (int n = 0; n < 1500; n++) begin
            int a;
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            a = (lcg >> 8) % 32;
            case ((lcg >> 4) % 4)
                0, 1: look(a, "R1");
                2: if (!present(a)) fill(a, 32'(lcg), (lcg >> 3) & 1, "R9");
                   else idle("R9");
                default: idle("R8");
            endcase
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule